// File: doc/BRIEF.md
# Memory-Stack Processor Core

This block is a compact 32-bit processor for running supervisory firmware next to custom logic. It keeps almost no architectural state. A program counter, a stack pointer and a cached copy of the top stack entry are its only registers. Every other operand lives in a push-down stack in ordinary memory. Instructions are one byte wide. They are fetched as whole words through a single synchronous memory port, and the byte the program counter points at is picked out of the word.

The core runs the required opcode set directly: immediates, stack-relative load/store/add, memory load/store, stack-pointer moves, add/and/or/not/bit-reverse, jumps through the stack, no-op and breakpoint. Each opcode in the emulation group traps to its own 32-byte vector, so that firmware can supply the missing instructions. The trap pushes the return address first, so the handler can return with POPPC. A single edge-triggered interrupt enters the vector at byte 32 in the same way. A breakpoint stops the core and raises a break output, which stays high until reset.

Top module: `stkcpu_core`

## Requirements
- R1: When reset is released, the core's first access is an instruction read of address 0, and the break output is low.
- R2: Every memory access uses a word-aligned address (the low two bits are zero), and at most one of read and write is active in a cycle. Read data returns one cycle after the read. The instruction byte is taken big-endian from the fetched word: PC low bits 0 select bits 31:24, and 3 selects bits 7:0.
- R3: Opcode 1xxxxxxx pushes its 7-bit field sign-extended. When it directly follows another such opcode, it instead shifts the top entry left by 7 and places the field in the low 7 bits.
- R4: The stack grows downward in 4-byte steps from the reset value 0x3F8. A push first decrements SP by 4 and then writes to the new SP. PUSHSP (0x02) pushes the SP value held before the push. POPSP (0x0D) pops the top entry into SP.
- R5: ADD (0x05), AND (0x06) and OR (0x07) replace the top two entries with one result. NOT (0x09) inverts the top entry, and FLIP (0x0A) reverses its bit order.
- R6: LOAD (0x08) replaces the address on top with the word read from it. STORE (0x0C) writes the second entry to the address held in the top entry, then pops both.
- R7: For an offset of n words: LOADSP (011nnnnn) pushes the word at SP+4n. STORESP (010nnnnn) writes the top entry to SP+4n, using the SP before the pop, then pops. ADDSP (0001nnnn) adds the word at SP+4n to the top entry.
- R8: EMULATE (001nnnnn) pushes the address of the next instruction and jumps to n*32. POPPC (0x04) pops the top entry into the PC.
- R9: BREAKPOINT (0x00) raises the break output, which stays high until reset. While the output is high the core makes no memory access.
- R10: NOP (0x0B) and the unassigned codes 0x01, 0x03, 0x0E and 0x0F change nothing except advancing the PC by one.
- R11: A rising edge on the interrupt input is latched. It is taken at the next instruction boundary that is not inside an immediate chain: the core pushes the PC and jumps to address 32. A level held high does not fire again, and each new rising edge fires once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request, edge-triggered |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| halted | output | 1 | Break output, set by BREAKPOINT |

## Verification
The checker watches on every cycle that accesses stay aligned and never mix a read with a write. It also checks that the first access after reset is a fetch at 0, that a halted core stays halted and silent on the bus, and that every interrupt entry and emulation trap lands on a 32-byte vector with the stack pointer moved down by one word. Only the bench's programs can show that data values are right. Those programs cover the arithmetic and bit-reverse results, sign extension and immediate chaining, stack-relative addressing at the correct offsets, the return through POPPC, and an interrupt that fires once per edge and returns to the correct address.

// File: rtl/stkcpu_pkg.sv
package stkcpu_pkg;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DEC, ST_EXEC, ST_MEM, ST_RELOAD, ST_TOS, ST_HALT
  } state_e;

  typedef enum logic [4:0] {
    OP_BRK, OP_IM, OP_STSP, OP_LDSP, OP_EMU, OP_ADDSP, OP_POPPC,
    OP_LOAD, OP_STORE, OP_PUSHSP, OP_POPSP, OP_ADD, OP_AND, OP_OR,
    OP_NOT, OP_FLIP, OP_NOP
  } op_e;

endpackage

// File: rtl/stkcpu_decode.sv
module stkcpu_decode
  import stkcpu_pkg::*;
(
  input  logic [7:0] op,
  output op_e        cls,
  output logic [4:0] arg
);

  always_comb begin
    casez (op)
      8'b1???????: cls = OP_IM;
      8'b010?????: cls = OP_STSP;
      8'b011?????: cls = OP_LDSP;
      8'b001?????: cls = OP_EMU;
      8'b0001????: cls = OP_ADDSP;
      8'h00:       cls = OP_BRK;
      8'h02:       cls = OP_PUSHSP;
      8'h04:       cls = OP_POPPC;
      8'h05:       cls = OP_ADD;
      8'h06:       cls = OP_AND;
      8'h07:       cls = OP_OR;
      8'h08:       cls = OP_LOAD;
      8'h09:       cls = OP_NOT;
      8'h0A:       cls = OP_FLIP;
      8'h0C:       cls = OP_STORE;
      8'h0D:       cls = OP_POPSP;
      default:     cls = OP_NOP;
    endcase
    arg = (cls == OP_ADDSP) ? {1'b0, op[3:0]} : op[4:0];
  end

endmodule

// File: rtl/stkcpu_alu.sv
module stkcpu_alu
  import stkcpu_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e          cls,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  logic [DW-1:0] rev;

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign rev[i] = a[DW-1-i];
  end

  always_comb begin
    case (cls)
      OP_ADD, OP_ADDSP: y = a + b;
      OP_AND:           y = a & b;
      OP_OR:            y = a | b;
      OP_NOT:           y = ~a;
      OP_FLIP:          y = rev;
      OP_LOAD:          y = b;
      default:          y = a;
    endcase
  end

endmodule

// File: rtl/stkcpu_irqlatch.sv
module stkcpu_irqlatch (
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic take,
  output logic pend
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      irq_q <= irq;
      if (irq && !irq_q) pend <= 1'b1;
      else if (take)     pend <= 1'b0;
    end
  end

endmodule

// File: rtl/stkcpu_core.sv
module stkcpu_core
  import stkcpu_pkg::*;
#(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] SP_INIT = DW'('h3F8),
  parameter int            VEC_SZ  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);

  localparam int            WB  = DW / 8;
  localparam int            LB  = $clog2(WB);
  localparam int            VSH = $clog2(VEC_SZ);
  localparam logic [DW-1:0] W1  = DW'(1);
  localparam logic [DW-1:0] W4  = DW'(WB);
  localparam logic [DW-1:0] W8  = DW'(2 * WB);
  localparam logic [DW-1:0] IRQ_VEC = DW'(VEC_SZ);

  state_e        st_q, st_d;
  logic [DW-1:0] pc_q, pc_d, sp_q, sp_d, tos_q, tos_d;
  logic [7:0]    op_q, op_d;
  logic          idim_q, idim_d, halt_q, halt_d;
  op_e           cls;
  logic [4:0]    arg;
  logic [DW-1:0] alu_y, off, imv, shifted, raw_addr;
  logic          irq_pend, irq_take;

  stkcpu_decode u_dec (.op(op_q), .cls(cls), .arg(arg));

  stkcpu_alu #(.DW(DW)) u_alu (.cls(cls), .a(tos_q), .b(mem_rdata), .y(alu_y));

  stkcpu_irqlatch u_irq (.clk(clk), .rst(rst), .irq(irq), .take(irq_take), .pend(irq_pend));

  assign off     = {{(DW-7){1'b0}}, arg, 2'b00};
  assign imv     = idim_q ? {tos_q[DW-8:0], op_q[6:0]} : {{(DW-7){op_q[6]}}, op_q[6:0]};
  assign shifted = mem_rdata << {pc_q[LB-1:0], 3'b000};
  assign mem_addr = {raw_addr[DW-1:LB], {LB{1'b0}}};
  assign halted  = halt_q;

  always_comb begin
    st_d = st_q; pc_d = pc_q; sp_d = sp_q; tos_d = tos_q;
    op_d = op_q; idim_d = idim_q; halt_d = halt_q;
    mem_rd = 1'b0; mem_wr = 1'b0; raw_addr = pc_q; mem_wdata = tos_q;
    irq_take = 1'b0;
    case (st_q)
      ST_FETCH: begin
        if (irq_pend && !idim_q) begin
          irq_take = 1'b1;
          mem_wr = 1'b1; raw_addr = sp_q - W4; mem_wdata = pc_q;
          sp_d = sp_q - W4; tos_d = pc_q; pc_d = IRQ_VEC;
        end else begin
          mem_rd = 1'b1; raw_addr = pc_q; st_d = ST_DEC;
        end
      end
      ST_DEC: begin
        op_d = shifted[DW-1 -: 8];
        st_d = ST_EXEC;
      end
      ST_EXEC: begin
        idim_d = 1'b0; pc_d = pc_q + W1; st_d = ST_FETCH;
        case (cls)
          OP_IM: begin
            idim_d = 1'b1; mem_wr = 1'b1; mem_wdata = imv; tos_d = imv;
            if (idim_q) raw_addr = sp_q;
            else begin raw_addr = sp_q - W4; sp_d = sp_q - W4; end
          end
          OP_EMU: begin
            mem_wr = 1'b1; raw_addr = sp_q - W4; mem_wdata = pc_q + W1;
            sp_d = sp_q - W4; tos_d = pc_q + W1;
            pc_d = {{(DW-5-VSH){1'b0}}, arg, {VSH{1'b0}}};
          end
          OP_STSP: begin
            mem_wr = 1'b1; raw_addr = sp_q + off;
            sp_d = sp_q + W4; st_d = ST_RELOAD;
          end
          OP_LDSP, OP_ADDSP: begin
            mem_rd = 1'b1; raw_addr = sp_q + off; st_d = ST_MEM;
          end
          OP_ADD, OP_AND, OP_OR: begin
            mem_rd = 1'b1; raw_addr = sp_q + W4; sp_d = sp_q + W4; st_d = ST_MEM;
          end
          OP_STORE: begin
            mem_rd = 1'b1; raw_addr = sp_q + W4; st_d = ST_MEM;
          end
          OP_LOAD: begin
            mem_rd = 1'b1; raw_addr = tos_q; st_d = ST_MEM;
          end
          OP_POPPC: begin
            pc_d = tos_q; sp_d = sp_q + W4; st_d = ST_RELOAD;
          end
          OP_POPSP: begin
            sp_d = tos_q; st_d = ST_RELOAD;
          end
          OP_PUSHSP: begin
            mem_wr = 1'b1; raw_addr = sp_q - W4; mem_wdata = sp_q;
            sp_d = sp_q - W4; tos_d = sp_q;
          end
          OP_NOT, OP_FLIP: begin
            mem_wr = 1'b1; raw_addr = sp_q; mem_wdata = alu_y; tos_d = alu_y;
          end
          OP_BRK: begin
            pc_d = pc_q; halt_d = 1'b1; st_d = ST_HALT;
          end
          default: ;
        endcase
      end
      ST_MEM: begin
        st_d = ST_FETCH;
        case (cls)
          OP_LDSP: begin
            mem_wr = 1'b1; raw_addr = sp_q - W4; mem_wdata = mem_rdata;
            sp_d = sp_q - W4; tos_d = mem_rdata;
          end
          OP_STORE: begin
            mem_wr = 1'b1; raw_addr = tos_q; mem_wdata = mem_rdata;
            sp_d = sp_q + W8; st_d = ST_RELOAD;
          end
          default: begin
            mem_wr = 1'b1; raw_addr = sp_q; mem_wdata = alu_y; tos_d = alu_y;
          end
        endcase
      end
      ST_RELOAD: begin
        mem_rd = 1'b1; raw_addr = sp_q; st_d = ST_TOS;
      end
      ST_TOS: begin
        tos_d = mem_rdata; st_d = ST_FETCH;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_FETCH;
      pc_q   <= '0;
      sp_q   <= SP_INIT;
      tos_q  <= '0;
      op_q   <= '0;
      idim_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      sp_q   <= sp_d;
      tos_q  <= tos_d;
      op_q   <= op_d;
      idim_q <= idim_d;
      halt_q <= halt_d;
    end
  end

endmodule

// File: rtl/stkcpu_chk.sv
module stkcpu_chk
  import stkcpu_pkg::*;
#(
  parameter int DW     = 32,
  parameter int VEC_SZ = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_addr,
  input logic          halted,
  input logic          irq_take,
  input state_e        st,
  input op_e           cls,
  input logic [DW-1:0] pc,
  input logic [DW-1:0] sp
);

  localparam int VSH = $clog2(VEC_SZ);

  // R1
  rst_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_rd && mem_addr == '0 && !halted));

  // R2
  align_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00));

  // R2
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr));

  // R11
  irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> (pc == DW'(VEC_SZ) && sp == $past(sp) - DW'(4)));

  // R8
  emu_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC && cls == OP_EMU) |=> (pc[VSH-1:0] == '0 && sp == $past(sp) - DW'(4)));

endmodule

bind stkcpu_core stkcpu_chk #(.DW(DW), .VEC_SZ(VEC_SZ)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .halted(halted), .irq_take(irq_take), .st(st_q), .cls(cls), .pc(pc_q), .sp(sp_q)
);

// File: tb/sim_stkcpu_core.sv
module sim_stkcpu_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic        mem_rd, mem_wr, halted;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [0:255];
  int          n_chk = 0;
  int          n_err = 0;
  int          cyc = 0;
  int          pp = 0;

  always #2 clk = ~clk;

  stkcpu_core u0 (
    .clk(clk), .rst(rst), .irq(irq), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] rd(input int a);
    return mem[a[9:2]];
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    pp = 0;
  endtask

  task automatic put(input int a, input logic [7:0] b);
    mem[a[9:2]][31 - 8*(a % 4) -: 8] = b;
  endtask

  task automatic emit(input logic [7:0] b);
    put(pp, b);
    pp++;
  endtask

  task automatic push32(input logic [31:0] v);
    emit({1'b1, v[31], v[31], v[31], v[31:28]});
    emit({1'b1, v[27:21]});
    emit({1'b1, v[20:14]});
    emit({1'b1, v[13:7]});
    emit({1'b1, v[6:0]});
    emit(8'h0B);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_prog(input string req);
    do_reset();
    for (int i = 0; i < 4000 && !halted; i++) @(negedge clk);
    chk({req, " halt reached"}, {31'b0, halted}, 32'h1);
  endtask

  task automatic t_reset();
    clear_mem();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 halted in reset", {31'b0, halted}, 32'h0);
    rst = 1'b0;
    #1;
    chk("R1 first access is read", {31'b0, mem_rd}, 32'h1);
    chk("R1 first address", mem_addr, 32'h0);
  endtask

  task automatic t_imm();
    clear_mem();
    emit(8'hFD); emit(8'h0B); emit(8'h84); emit(8'h80); emit(8'h0C);
    emit(8'h81); emit(8'hFF); emit(8'h80); emit(8'h0B);
    emit(8'h84); emit(8'h84); emit(8'h0C); emit(8'h00);
    run_prog("R3");
    chk("R3 sign-extended immediate (R2 lanes)", rd(32'h200), 32'hFFFF_FFFD);
    chk("R3 chained immediate", rd(32'h204), 32'h0000_7F80);
  endtask

  task automatic t_alu();
    logic [31:0] a, b;
    a = 32'h0F0F_1234; b = 32'h00FF_00FF;
    clear_mem();
    push32(a); push32(b); emit(8'h05); push32(32'h200); emit(8'h0C);
    push32(a); push32(b); emit(8'h06); push32(32'h204); emit(8'h0C);
    push32(a); push32(b); emit(8'h07); push32(32'h208); emit(8'h0C);
    push32(32'h0F0F_0000); emit(8'h09); push32(32'h20C); emit(8'h0C);
    push32(32'h1234_5678); emit(8'h0A); push32(32'h210); emit(8'h0C);
    emit(8'h00);
    run_prog("R5");
    chk("R5 ADD", rd(32'h200), a + b);
    chk("R5 AND", rd(32'h204), a & b);
    chk("R5 OR", rd(32'h208), a | b);
    chk("R5 NOT", rd(32'h20C), 32'hF0F0_FFFF);
    chk("R5 FLIP", rd(32'h210), 32'h1E6A_2C48);
  endtask

  task automatic t_load();
    clear_mem();
    mem[32'h300 >> 2] = 32'hCAFE_BABE;
    push32(32'h300); emit(8'h08); push32(32'h214); emit(8'h0C); emit(8'h00);
    run_prog("R6");
    chk("R6 LOAD then STORE", rd(32'h214), 32'hCAFE_BABE);
    chk("R6 source word unchanged", rd(32'h300), 32'hCAFE_BABE);
  endtask

  task automatic t_spops();
    clear_mem();
    emit(8'h91); emit(8'h02); push32(32'h200); emit(8'h0C);
    push32(32'h380); emit(8'h0D); emit(8'h02); push32(32'h204); emit(8'h0C);
    emit(8'h00);
    run_prog("R4");
    chk("R4 first push lands at 0x3F4", rd(32'h3F4), 32'h11);
    chk("R4 PUSHSP value", rd(32'h200), 32'h3F4);
    chk("R4 POPSP then PUSHSP", rd(32'h204), 32'h380);
  endtask

  task automatic t_stackrel();
    clear_mem();
    push32(10); push32(25); emit(8'h61); emit(8'h11);
    push32(32'h200); emit(8'h0C);
    push32(7); emit(8'h42);
    push32(32'h204); emit(8'h0C);
    push32(32'h208); emit(8'h0C);
    emit(8'h00);
    run_prog("R7");
    chk("R7 LOADSP 1 then ADDSP 1", rd(32'h200), 32'd35);
    chk("R7 STORESP 2 leaves entry", rd(32'h204), 32'd25);
    chk("R7 STORESP 2 target", rd(32'h208), 32'd7);
  endtask

  task automatic t_emulate();
    clear_mem();
    emit(8'h22);
    push32(32'h2A); emit(8'h84); emit(8'h9C); emit(8'h0C); emit(8'h00);
    put(64, 8'h60); put(65, 8'h84); put(66, 8'h98); put(67, 8'h0C); put(68, 8'h04);
    run_prog("R8");
    chk("R8 return address pushed", rd(32'h218), 32'h1);
    chk("R8 POPPC returned", rd(32'h21C), 32'h2A);
  endtask

  task automatic t_break_nop();
    clear_mem();
    push32(32'h5A);
    emit(8'h01); emit(8'h03); emit(8'h0E); emit(8'h0F); emit(8'h0B);
    emit(8'h84); emit(8'h80); emit(8'h0C); emit(8'h00);
    emit(8'h85); emit(8'h84); emit(8'h84); emit(8'h0C);
    run_prog("R9");
    chk("R10 value survives unassigned codes", rd(32'h200), 32'h5A);
    repeat (50) @(negedge clk);
    chk("R9 break output stays high", {31'b0, halted}, 32'h1);
    chk("R9 no read while halted", {31'b0, mem_rd}, 32'h0);
    chk("R9 code after break not run", rd(32'h204), 32'h0);
  endtask

  task automatic t_irq();
    clear_mem();
    for (int i = 0; i < 5; i++) put(i, 8'h0B);
    put(5, 8'h85); put(6, 8'h04);
    put(32, 8'h60); put(33, 8'h84); put(34, 8'hA0); put(35, 8'h0C);
    put(36, 8'h84); put(37, 8'hA4); put(38, 8'h08); put(39, 8'h81);
    put(40, 8'h05); put(41, 8'h84); put(42, 8'hA4); put(43, 8'h0C); put(44, 8'h04);
    do_reset();
    repeat (200) @(negedge clk);
    chk("R11 no entry before edge", rd(32'h224), 32'h0);
    irq = 1'b1;
    repeat (400) @(negedge clk);
    chk("R11 one entry for held level", rd(32'h224), 32'h1);
    chk("R11 return address outside chain", rd(32'h220), 32'h5);
    chk("R11 core still running", {31'b0, halted}, 32'h0);
    irq = 1'b0;
    repeat (20) @(negedge clk);
    irq = 1'b1;
    repeat (400) @(negedge clk);
    chk("R11 second edge enters again", rd(32'h224), 32'h2);
    irq = 1'b0;
  endtask

  initial begin
    t_reset();
    t_imm();
    t_alu();
    t_load();
    t_spops();
    t_stackrel();
    t_emulate();
    t_break_nop();
    t_irq();
    summary();
  end

endmodule